// File: doc/BRIEF.md
# Peripheral Clock Prescaler Network

This block produces single-cycle count-source enables for timers, serial channels and the A/D converter. Everything runs in one fast synchronous clock domain. Each slower clock arrives as a one-cycle tick enable, and each derived clock leaves as one. From a peripheral source tick stream it makes three fixed-ratio enables (undivided, divide-by-8 and divide-by-32) and an A/D clock enable. An optional halving stage sits in front of the fixed taps and the A/D enable. It must be switched on when a high-speed synthesized source feeds the peripherals.

A fifth enable has its own programmable divider with its own source. The source is one of four choices: the peripheral source, half the peripheral source, the external crystal tick, or the on-chip oscillator tick. The divider divides by twice a 4-bit code, and code zero passes the chosen input straight through. A sixth enable divides a low-speed sub-clock tick by 32, and it advances only while the sub-clock is flagged as running.

While wait mode is active with the stop option set, the peripheral source is gated. All dividers fed from it freeze and resume later from their held counts. Every enable output is registered: it appears one cycle after the input tick that causes it.

Top module: `pclk_prescaler`

## Requirements
- R1: While rst_n is low, and on the first sample after it rises, all six tick outputs are 0 and all divider counts are cleared.
- R2: With half_en = 0, each source tick makes tick_f1 high on the next cycle. tick_f8 joins it on every 8th such tick counted since reset, and tick_f32 on every 32nd.
- R3: With half_en = 1, only every 2nd source tick (a running parity of source ticks since reset, never reset by half_en) counts as a base tick. tick_f1, tick_f8 and tick_f32 then fire every 2, 16 and 64 source ticks. The count of base ticks carries across changes of half_en.
- R4: tick_ad fires on every source tick when half_en = 0, and on the same half-rate base ticks as tick_f1 when half_en = 1.
- R5: A tick_f32 pulse is always accompanied in the same cycle by tick_f8 and tick_f1.
- R6: f2n_sel picks the f2n input: 0 = peripheral source, 1 = the half-rate ticks of R3 (produced whatever half_en is), 2 = xin_tick, 3 = osc_tick.
- R7: For f2n_code n from 1 to 15, tick_f2n fires on every 2n-th selected input tick. For n = 0, every selected input tick passes to tick_f2n one cycle later.
- R8: In any cycle where f2n_sel or f2n_code differs from its value in the previous cycle, the f2n count clears, that cycle's input tick is ignored and no tick_f2n follows. Reset leaves the remembered setting at select 0, code 0.
- R9: While wait_stop and wait_mode are both 1, source ticks are ignored. tick_f1, tick_f8, tick_f32 and tick_ad stay low, and so does tick_f2n on selections 0 and 1. The counts hold and resume afterwards without an extra tick.
- R10: wait_mode without wait_stop has no effect on any output.
- R11: tick_c32 fires on every 32nd sub_tick that arrives with sub_running = 1. Sub ticks while sub_running = 0 are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 1 | Peripheral source tick enable |
| xin_tick | input | 1 | External crystal tick enable |
| osc_tick | input | 1 | On-chip oscillator tick enable |
| sub_tick | input | 1 | Sub-clock tick enable |
| sub_running | input | 1 | Sub-clock is running |
| half_en | input | 1 | Halve the source before fixed taps and A/D clock |
| f2n_sel | input | 2 | f2n input select |
| f2n_code | input | 4 | f2n divide code n (ratio 2n, 0 = undivided) |
| wait_stop | input | 1 | Stop peripheral source in wait mode |
| wait_mode | input | 1 | Wait mode is active |
| tick_f1 | output | 1 | Undivided (or halved) tap enable |
| tick_f8 | output | 1 | Divide-by-8 tap enable |
| tick_f32 | output | 1 | Divide-by-32 tap enable |
| tick_ad | output | 1 | A/D clock enable |
| tick_f2n | output | 1 | Programmable divider enable |
| tick_c32 | output | 1 | Sub-clock divide-by-32 enable |

## Verification
Several properties are checked on every cycle. A tick_f32 always lands together with tick_f8 and tick_f1. Fixed-tap and A/D ticks are silent in the cycle after a stop. The f2n count stays below its programmed limit and clears after a setting change. tick_c32 needs a running sub tick the cycle before. The exact ratios need the bench's scenarios, which compare every output every cycle against a reference model under random tick patterns. These cover the 1/8/32 versus 2/16/64 ratios, each f2n source and code, the ignored tick on reconfiguration, and resumption after wait stop without an extra pulse.

// File: rtl/pclk_pkg.sv
// Shared types and arithmetic for the peripheral clock prescaler.
package pclk_pkg;

  // Encoding of the f2n input selection.
  typedef enum logic [1:0] {
    F2N_PFC      = 2'd0,
    F2N_PFC_HALF = 2'd1,
    F2N_XIN      = 2'd2,
    F2N_OSC      = 2'd3
  } f2n_src_e;

  // True when the low 'lg' bits of a count are all ones, i.e. the tick
  // about to be counted completes a 2**lg period.
  function automatic logic tap_hit(input logic [7:0] cnt, input int unsigned lg);
    logic [7:0] mask;
    mask = 8'((1 << lg) - 1);
    return (cnt & mask) == mask;
  endfunction

  // Half-rate selection: a source tick counts only at odd parity.
  function automatic logic half_pick(input logic src, input logic parity);
    return src & parity;
  endfunction

endpackage

// File: rtl/pclk_tap_div.sv
// Optional halving stage plus one shared free-running counter feeding the
// fixed taps and the A/D enable. Counts only advance on base ticks.
module pclk_tap_div #(
  parameter int TAP_W   = 5,  // log2 of the widest tap (32)
  parameter int MID_LOG = 3   // log2 of the middle tap (8)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_tick,   // already gated by wait stop
  input  logic half_en,
  output logic half_tick,  // half-rate tick, always produced
  output logic t1,
  output logic t8,
  output logic t32,
  output logic tad
);
  import pclk_pkg::*;

  logic             parity;
  logic [TAP_W-1:0] cnt;
  logic             base_evt;
  logic             ad_evt;
  logic             hit_mid;
  logic             hit_top;

  assign half_tick = half_pick(src_tick, parity);
  assign base_evt  = half_en ? half_tick : src_tick;
  assign ad_evt    = half_en ? half_tick : src_tick;
  assign hit_mid   = tap_hit(8'(cnt), MID_LOG);
  assign hit_top   = tap_hit(8'(cnt), TAP_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parity <= 1'b0;
      cnt    <= '0;
      t1     <= 1'b0;
      t8     <= 1'b0;
      t32    <= 1'b0;
      tad    <= 1'b0;
    end else begin
      if (src_tick) parity <= ~parity;
      if (base_evt) cnt <= cnt + 1'b1;
      t1  <= base_evt;
      t8  <= base_evt & hit_mid;
      t32 <= base_evt & hit_top;
      tad <= ad_evt;
    end
  end

  // R5: widest tap always lands on the narrower ones
  p_f32_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    t32 |-> (t8 && t1));

  // R9: with no source tick the shared state is frozen
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !src_tick |=> ($stable(cnt) && $stable(parity)));

  // R3: in halved mode two consecutive source ticks never both count
  p_half_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick) |=> ($changed(parity) || !$past(src_tick) || !parity));

endmodule

// File: rtl/pclk_f2n_div.sv
// Programmable f2n divider: selectable input, ratio 2n, pass-through at n=0,
// count cleared whenever the setting changes.
module pclk_f2n_div #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic [CODE_W-1:0] code,
  input  logic              pfc_tick,
  input  logic              half_tick,
  input  logic              xin_tick,
  input  logic              osc_tick,
  output logic              tick_out
);
  import pclk_pkg::*;

  localparam int CNT_W = CODE_W + 1;

  logic              in_evt;
  logic              cfg_chg;
  logic [1:0]        prev_sel;
  logic [CODE_W-1:0] prev_code;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lim;
  logic              code_zero;

  always_comb begin
    case (f2n_src_e'(sel))
      F2N_PFC:      in_evt = pfc_tick;
      F2N_PFC_HALF: in_evt = half_tick;
      F2N_XIN:      in_evt = xin_tick;
      default:      in_evt = osc_tick;
    endcase
  end

  assign cfg_chg   = (sel != prev_sel) || (code != prev_code);
  assign code_zero = (code == '0);
  assign lim       = {code, 1'b0} - {{CODE_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sel  <= '0;
      prev_code <= '0;
      cnt       <= '0;
      tick_out  <= 1'b0;
    end else begin
      prev_sel  <= sel;
      prev_code <= code;
      if (cfg_chg) begin
        cnt      <= '0;
        tick_out <= 1'b0;
      end else if (in_evt) begin
        if (code_zero) begin
          tick_out <= 1'b1;
        end else if (cnt == lim) begin
          cnt      <= '0;
          tick_out <= 1'b1;
        end else begin
          cnt      <= cnt + 1'b1;
          tick_out <= 1'b0;
        end
      end else begin
        tick_out <= 1'b0;
      end
    end
  end

  // R7: count never runs past the programmed period
  p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_chg && !code_zero) |-> (cnt <= lim));

  // R8: a setting change clears the count and suppresses output
  p_clear_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (cnt == '0 && !tick_out));

  // R6: every output tick is caused by a selected input tick
  p_out_needs_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> $past(in_evt));

endmodule

// File: rtl/pclk_sub_div.sv
// Sub-clock divider: counts sub ticks only while the sub clock runs.
module pclk_sub_div #(
  parameter int SUB_LOG = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sub_tick,
  input  logic running,
  output logic tick_out
);
  import pclk_pkg::*;

  logic [SUB_LOG-1:0] cnt;
  logic               evt;

  assign evt = sub_tick & running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      tick_out <= 1'b0;
    end else begin
      if (evt) cnt <= cnt + 1'b1;
      tick_out <= evt & tap_hit(8'(cnt), SUB_LOG);
    end
  end

  // R11: output only follows a counted running sub tick
  p_c32_only_running_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> ($past(sub_tick) && $past(running)));

  // R11: stopped sub clock freezes the count
  p_c32_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(cnt));

endmodule

// File: rtl/pclk_prescaler.sv
// Peripheral clock prescaler network: top level.
module pclk_prescaler #(
  parameter int TAP_W   = 5,
  parameter int MID_LOG = 3,
  parameter int CODE_W  = 4,
  parameter int SUB_LOG = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_tick,
  input  logic              xin_tick,
  input  logic              osc_tick,
  input  logic              sub_tick,
  input  logic              sub_running,
  input  logic              half_en,
  input  logic [1:0]        f2n_sel,
  input  logic [CODE_W-1:0] f2n_code,
  input  logic              wait_stop,
  input  logic              wait_mode,
  output logic              tick_f1,
  output logic              tick_f8,
  output logic              tick_f32,
  output logic              tick_ad,
  output logic              tick_f2n,
  output logic              tick_c32
);

  logic src_stopped;
  logic pfc_evt;
  logic half_evt;

  // Wait-stop gating of the peripheral source.
  assign src_stopped = wait_stop & wait_mode;
  assign pfc_evt     = src_tick & ~src_stopped;

  pclk_tap_div #(
    .TAP_W   (TAP_W),
    .MID_LOG (MID_LOG)
  ) u_taps (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_tick  (pfc_evt),
    .half_en   (half_en),
    .half_tick (half_evt),
    .t1        (tick_f1),
    .t8        (tick_f8),
    .t32       (tick_f32),
    .tad       (tick_ad)
  );

  pclk_f2n_div #(
    .CODE_W (CODE_W)
  ) u_f2n (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (f2n_sel),
    .code      (f2n_code),
    .pfc_tick  (pfc_evt),
    .half_tick (half_evt),
    .xin_tick  (xin_tick),
    .osc_tick  (osc_tick),
    .tick_out  (tick_f2n)
  );

  pclk_sub_div #(
    .SUB_LOG (SUB_LOG)
  ) u_sub (
    .clk      (clk),
    .rst_n    (rst_n),
    .sub_tick (sub_tick),
    .running  (sub_running),
    .tick_out (tick_c32)
  );

  // R9: a stopped source yields silent fixed taps and A/D enable
  p_silent_when_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(src_stopped) |-> (!tick_f1 && !tick_f8 && !tick_f32 && !tick_ad));

  // R10: wait mode alone leaves the undivided tap running
  p_wait_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_mode && !wait_stop && src_tick && !half_en) |=> tick_f1);

  // R4: A/D enable never fires without the matching tap
  p_ad_with_f1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_ad |-> tick_f1);

endmodule

// File: tb/test_pclk_prescaler.sv
module test_pclk_prescaler;

  logic clk = 1'b0;
  logic rst_n;
  logic src_tick, xin_tick, osc_tick, sub_tick, sub_running, half_en;
  logic [1:0] f2n_sel;
  logic [3:0] f2n_code;
  logic wait_stop, wait_mode;
  logic tick_f1, tick_f8, tick_f32, tick_ad, tick_f2n, tick_c32;

  always #10 clk = ~clk;  // 50 MHz

  pclk_prescaler i_pclk_prescaler (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .xin_tick(xin_tick),
    .osc_tick(osc_tick), .sub_tick(sub_tick), .sub_running(sub_running),
    .half_en(half_en), .f2n_sel(f2n_sel), .f2n_code(f2n_code),
    .wait_stop(wait_stop), .wait_mode(wait_mode),
    .tick_f1(tick_f1), .tick_f8(tick_f8), .tick_f32(tick_f32),
    .tick_ad(tick_ad), .tick_f2n(tick_f2n), .tick_c32(tick_c32));

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // Reference model state
  int m_srcs, m_base, m_f2n, m_sub;
  logic [1:0] m_psel;
  logic [3:0] m_pcode;
  logic e1, e8, e32, ead, ef, ec;
  string tag_tap, tag_ad, tag_f, f2n_tag;
  int n8, n32, nf;

  task automatic chk(string tag, string what, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic f2n_step(logic inp, logic chg, logic [3:0] n);
    if (chg) begin m_f2n = 0; return 1'b0; end
    if (!inp) return 1'b0;
    if (n == 0) return 1'b1;
    m_f2n++;
    if (m_f2n == 2 * int'(n)) begin m_f2n = 0; return 1'b1; end
    return 1'b0;
  endfunction

  task automatic model_eval();
    logic stop, g, half, base, inp, chg;
    stop = wait_stop & wait_mode;
    g = src_tick & ~stop;
    half = 1'b0;
    if (g) begin m_srcs++; half = (m_srcs % 2 == 0); end
    base = half_en ? half : g;
    e1 = base; e8 = 1'b0; e32 = 1'b0;
    if (base) begin m_base++; e8 = (m_base % 8 == 0); e32 = (m_base % 32 == 0); end
    ead = half_en ? half : g;
    case (f2n_sel)
      2'd0: inp = g;
      2'd1: inp = half;
      2'd2: inp = xin_tick;
      default: inp = osc_tick;
    endcase
    chg = (f2n_sel != m_psel) || (f2n_code != m_pcode);
    ef = f2n_step(inp, chg, f2n_code);
    m_psel = f2n_sel; m_pcode = f2n_code;
    ec = 1'b0;
    if (sub_tick && sub_running) begin m_sub++; ec = (m_sub % 32 == 0); end
    tag_tap = stop ? "R9" : (wait_mode ? "R10" : (half_en ? "R3" : "R2"));
    tag_ad  = stop ? "R9" : "R4";
    tag_f   = chg ? "R8" : f2n_tag;
  endtask

  task automatic cycle();
    model_eval();
    @(negedge clk);
    chk(tag_tap, "tick_f1", tick_f1, e1);
    chk(tag_tap, "tick_f8", tick_f8, e8);
    chk(tag_tap, "tick_f32", tick_f32, e32);
    chk(tag_ad, "tick_ad", tick_ad, ead);
    chk(tag_f, "tick_f2n", tick_f2n, ef);
    chk("R11", "tick_c32", tick_c32, ec);
    if (tick_f32) chk("R5", "f32 aligned", tick_f8 & tick_f1, 1'b1);
    n8 += int'(tick_f8); n32 += int'(tick_f32); nf += int'(tick_f2n);
  endtask

  task automatic rand_aux();
    xin_tick = 1'($urandom % 2);
    osc_tick = 1'($urandom % 3 == 0);
    sub_tick = 1'($urandom % 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; src_tick = 0; xin_tick = 0; osc_tick = 0; sub_tick = 0;
    sub_running = 0; half_en = 0; f2n_sel = 0; f2n_code = 0;
    wait_stop = 0; wait_mode = 0;
    m_srcs = 0; m_base = 0; m_f2n = 0; m_sub = 0; m_psel = 0; m_pcode = 0;
    f2n_tag = "R7"; n8 = 0; n32 = 0; nf = 0;
    repeat (3) @(negedge clk);
    src_tick = 1;  // ticks during reset must not leak
    @(negedge clk);
    chk("R1", "reset outputs", |{tick_f1, tick_f8, tick_f32, tick_ad, tick_f2n, tick_c32}, 1'b0);
    rst_n = 1;
    src_tick = 0;
    chk("R1", "first sample after reset", |{tick_f1, tick_f8, tick_f32, tick_ad, tick_f2n, tick_c32}, 1'b0);

    // R2: undivided source, continuous ticks
    n8 = 0; n32 = 0;
    for (int i = 0; i < 64; i++) begin src_tick = 1; cycle(); end
    chk("R2", "f8 count over 64 ticks", 1'(n8 == 8), 1'b1);
    chk("R2", "f32 count over 64 ticks", 1'(n32 == 2), 1'b1);

    // R3: halved source
    half_en = 1; n8 = 0; n32 = 0;
    for (int i = 0; i < 128; i++) begin src_tick = 1; cycle(); end
    chk("R3", "f8 count over 128 ticks", 1'(n8 == 8), 1'b1);
    chk("R3", "f32 count over 128 ticks", 1'(n32 == 2), 1'b1);

    // R7: directed f2n, source 0, code 3 -> every 6 ticks
    half_en = 0; f2n_sel = 0; f2n_code = 3; src_tick = 1;
    cycle();  // change cycle (R8)
    nf = 0;
    for (int i = 0; i < 60; i++) cycle();
    chk("R7", "f2n code 3 count over 60 ticks", 1'(nf == 10), 1'b1);
    f2n_code = 0; cycle(); nf = 0;
    for (int i = 0; i < 20; i++) cycle();
    chk("R7", "f2n pass-through count", 1'(nf == 20), 1'b1);

    // R8: change mid-period
    f2n_code = 2;
    for (int i = 0; i < 5; i++) cycle();
    f2n_code = 5;
    for (int i = 0; i < 15; i++) cycle();

    // R6: each source, random ticks
    f2n_tag = "R6";
    for (int s = 0; s < 4; s++) begin
      f2n_sel = 2'(s); f2n_code = 4'(1 + s);
      for (int i = 0; i < 150; i++) begin
        src_tick = 1'($urandom % 2); rand_aux(); cycle();
      end
    end
    f2n_tag = "R7";

    // R9: wait stop, then resume
    f2n_sel = 0; f2n_code = 1; half_en = 0;
    for (int i = 0; i < 13; i++) begin src_tick = 1; cycle(); end
    wait_stop = 1; wait_mode = 1; f2n_tag = "R9";
    for (int i = 0; i < 80; i++) begin src_tick = 1'($urandom % 2); rand_aux(); cycle(); end
    wait_mode = 0; f2n_tag = "R7";
    for (int i = 0; i < 40; i++) begin src_tick = 1; cycle(); end

    // R10: wait mode alone
    wait_stop = 0; wait_mode = 1;
    for (int i = 0; i < 80; i++) begin src_tick = 1'($urandom % 2); rand_aux(); cycle(); end
    wait_mode = 0;

    // R11: sub clock stopped then running
    sub_running = 0;
    for (int i = 0; i < 100; i++) begin src_tick = 1'($urandom % 2); rand_aux(); cycle(); end
    sub_running = 1;
    for (int i = 0; i < 200; i++) begin src_tick = 1'($urandom % 2); rand_aux(); cycle(); end

    // Mixed random
    for (int i = 0; i < 3000; i++) begin
      src_tick = 1'($urandom % 2); rand_aux();
      if ($urandom % 50 == 0) half_en = ~half_en;
      if ($urandom % 40 == 0) f2n_sel = 2'($urandom);
      if ($urandom % 40 == 0) f2n_code = 4'($urandom);
      if ($urandom % 60 == 0) sub_running = ~sub_running;
      if ($urandom % 70 == 0) wait_stop = 1'($urandom % 2);
      if ($urandom % 30 == 0) wait_mode = ~wait_mode;
      cycle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule